// File: doc/BRIEF.md
# Pen-Down Trigger Rate Limiter

This block sits between a touch controller's pen-down line and the engine that scans the converter channels. It converts a level-sensitive pen interrupt into paced scan-start pulses and keeps issuing scans for a bounded number of intervals after the pen is lifted, so the final position is captured before the controller goes quiet. While a scan runs, the interrupt input is masked, because switching channels on the converter disturbs the pen line and would otherwise retrigger the block.

The controller has five states: off, idle, polling with the interrupt masked, polling with the interrupt open, and armed (a scan is in flight or its interval is running). A poll counter decides when the interrupt is opened again and when polling stops. An internal interval timer, counted in clock cycles, paces the scans. After each scan the timer is loaded with the interval minus the measured scan duration, so scans start at a steady rate whatever their length. The enable level switches the whole controller on and off.

Top module: `pen_trigger_ctrl`

## Requirements
- R1: While and right after reset the controller is off: `irq_mask`=1, `scan_start`=0, `state_err`=0.
- R2: With `enable` high in the off state, the next cycle enters idle and drives `irq_mask`=0.
- R3: With `enable` low the controller goes off on the next edge with `irq_mask`=1 and the timer cancelled; no `scan_start` or `state_err` follows until it is enabled again and a pen event occurs.
- R4: `pen_irq_raw` passes through SYNC_STAGES (default 2) flip-flops. A high level seen while enabled, not off and unmasked gives `scan_start`=1 (one cycle) with `irq_mask`=1 three cycles after it was sampled, clears the poll count and cancels the timer.
- R5: The pen input has no effect while `irq_mask` is 1, including in the off state.
- R6: `scan_done` in cycle s+k, where `scan_start` was high in cycle s, loads the timer with INTERVAL_CYC−k. A loaded value L expires in the cycle L+1 after the load edge.
- R7: An expiry in the armed state with poll count below POLL_MAX (6) increments the count and reloads INTERVAL_CYC. If the new count is at least POLL_MIN (3), the state is polling-open and `irq_mask`=0; otherwise it is polling-masked and `irq_mask` stays 1.
- R8: An expiry in the armed state with the count at POLL_MAX enters idle with `irq_mask`=0. A single pen event with no further pen activity therefore yields exactly 1+POLL_MAX scan starts.
- R9: An expiry in either polling state issues `scan_start` and returns to the armed state with `irq_mask`=1.
- R10: A pen event seen in the polling-open state restarts the sequence with the poll count at zero, so a pen held down keeps polling indefinitely.
- R11: A timer expiry in the idle state produces a one-cycle `state_err` pulse and no other effect.
- R12: Priority per cycle: `enable` low, then leaving the off state, then a pen event, then a timer expiry, then `scan_done`.
- R13: The scan duration counter saturates at INTERVAL_CYC, so a scan longer than the interval reloads zero and expires in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller on/off level |
| pen_irq_raw | input | 1 | Asynchronous pen-down level, active high |
| scan_done | input | 1 | One-cycle pulse when a scan completes |
| scan_start | output | 1 | One-cycle pulse requesting a scan |
| irq_mask | output | 1 | High while the pen interrupt is ignored |
| state_err | output | 1 | One-cycle pulse on a timer expiry in idle |

## Verification
The assertions assume that `scan_done` is a single-cycle pulse and that `pen_irq_raw` may change at any time. They do not assume that `scan_done` follows every `scan_start`. The random stimulus therefore answers most scan starts after a random delay, some shorter and some longer than the interval, and also injects stray `scan_done` pulses in idle, brief `enable` drops and pen bursts of random length. Directed segments cover the full post-lift poll sequence, a pen held down, the idle expiry error and shutdown while polling.

// File: rtl/pentrig_pkg.sv
package pentrig_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_POLL,
        ST_POLL_UNMASK,
        ST_ARM
    } trig_state_e;

    // Command from the controller to the interval timer
    typedef struct packed {
        logic cancel;     // stop the timer
        logic load_full;  // reload a whole interval
        logic load_scan;  // reload interval minus measured scan time
        logic mark;       // a scan starts: restart the duration count
    } tmr_cmd_t;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/pt_pen_sync.sv
module pt_pen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[g] <= 1'b0;
                    else     chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pt_interval_timer.sv
module pt_interval_timer
    import pentrig_pkg::*;
#(
    parameter int INTERVAL_CYC = 2500000
) (
    input  logic     clk,
    input  logic     rst,
    input  tmr_cmd_t cmd,
    output logic     expire
);
    localparam int CW = cnt_width(INTERVAL_CYC);
    localparam logic [CW-1:0] INT_V = CW'(INTERVAL_CYC);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] dur_q;
    logic          run_q;

    assign expire = run_q && (cnt_q == '0);

    // duration since the last scan start, held at the interval
    always_ff @(posedge clk) begin
        if (rst)              dur_q <= INT_V;
        else if (cmd.mark)    dur_q <= '0;
        else if (dur_q != INT_V) dur_q <= dur_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (cmd.cancel) begin
            run_q <= 1'b0;
        end else if (cmd.load_full) begin
            run_q <= 1'b1;
            cnt_q <= INT_V;
        end else if (cmd.load_scan) begin
            run_q <= 1'b1;
            cnt_q <= INT_V - dur_q;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    p_cnt_bound_r13: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q <= INT_V));

    p_cancel_stops_r3: assert property (@(posedge clk) disable iff (rst)
        cmd.cancel |=> !expire);

    p_full_reload_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd.load_full && !cmd.cancel) |=> (run_q && cnt_q == INT_V));
endmodule

// File: rtl/pt_ctrl_fsm.sv
module pt_ctrl_fsm
    import pentrig_pkg::*;
#(
    parameter int POLL_MIN = 3,
    parameter int POLL_MAX = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     enable,
    input  logic     pen_level,
    input  logic     expire,
    input  logic     scan_done,
    output tmr_cmd_t tmr_cmd,
    output logic     scan_start,
    output logic     irq_mask,
    output logic     state_err
);
    localparam int PCW = cnt_width(POLL_MAX);
    localparam logic [PCW-1:0] PC_MIN = PCW'(POLL_MIN);
    localparam logic [PCW-1:0] PC_MAX = PCW'(POLL_MAX);

    trig_state_e    st_q, st_d;
    logic [PCW-1:0] pc_q, pc_d;
    logic           mask_d, start_d, err_d;
    logic           pen_evt;

    always_comb begin
        st_d    = st_q;
        pc_d    = pc_q;
        mask_d  = irq_mask;
        start_d = 1'b0;
        err_d   = 1'b0;
        tmr_cmd = '0;
        pen_evt = enable && (st_q != ST_OFF) && pen_level && !irq_mask;

        if (!enable) begin
            st_d           = ST_OFF;
            mask_d         = 1'b1;
            tmr_cmd.cancel = 1'b1;
        end else if (st_q == ST_OFF) begin
            st_d   = ST_IDLE;
            mask_d = 1'b0;
        end else if (pen_evt) begin
            st_d           = ST_ARM;
            pc_d           = '0;
            mask_d         = 1'b1;
            start_d        = 1'b1;
            tmr_cmd.cancel = 1'b1;
        end else if (expire) begin
            unique case (st_q)
                ST_ARM: begin
                    if (pc_q < PC_MAX) begin
                        pc_d              = pc_q + 1'b1;
                        tmr_cmd.load_full = 1'b1;
                        if (pc_d >= PC_MIN) begin
                            st_d   = ST_POLL_UNMASK;
                            mask_d = 1'b0;
                        end else begin
                            st_d = ST_POLL;
                        end
                    end else begin
                        st_d   = ST_IDLE;
                        mask_d = 1'b0;
                    end
                end
                ST_POLL_UNMASK: begin
                    mask_d  = 1'b1;
                    st_d    = ST_ARM;
                    start_d = 1'b1;
                end
                ST_POLL: begin
                    st_d    = ST_ARM;
                    start_d = 1'b1;
                end
                ST_IDLE: err_d = 1'b1;
                default: ;
            endcase
        end else if (scan_done) begin
            tmr_cmd.load_scan = 1'b1;
        end
        tmr_cmd.mark = start_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_OFF;
            pc_q       <= '0;
            irq_mask   <= 1'b1;
            scan_start <= 1'b0;
            state_err  <= 1'b0;
        end else begin
            st_q       <= st_d;
            pc_q       <= pc_d;
            irq_mask   <= mask_d;
            scan_start <= start_d;
            state_err  <= err_d;
        end
    end

    p_start_masked_r9: assert property (@(posedge clk) disable iff (rst)
        scan_start |-> irq_mask);

    p_off_masked_r3: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (irq_mask && !scan_start && !state_err));

    p_start_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        scan_start |=> !scan_start);

    p_poll_cap_r7: assert property (@(posedge clk) disable iff (rst)
        pc_q <= PC_MAX);

    p_pen_restart_r10: assert property (@(posedge clk) disable iff (rst)
        pen_evt |=> (scan_start && pc_q == '0));

    p_err_idle_r11: assert property (@(posedge clk) disable iff (rst)
        state_err |-> ($past(st_q) == ST_IDLE));

    p_idle_open_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE) |-> !irq_mask);
endmodule

// File: rtl/pen_trigger_ctrl.sv
module pen_trigger_ctrl
    import pentrig_pkg::*;
#(
    parameter int INTERVAL_CYC = 2500000,
    parameter int POLL_MIN     = 3,
    parameter int POLL_MAX     = 6,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic pen_irq_raw,
    input  logic scan_done,
    output logic scan_start,
    output logic irq_mask,
    output logic state_err
);
    logic     pen_level;
    logic     expire;
    tmr_cmd_t tmr_cmd;

    pt_pen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pen_irq_raw),
        .q   (pen_level)
    );

    pt_ctrl_fsm #(.POLL_MIN(POLL_MIN), .POLL_MAX(POLL_MAX)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .pen_level  (pen_level),
        .expire     (expire),
        .scan_done  (scan_done),
        .tmr_cmd    (tmr_cmd),
        .scan_start (scan_start),
        .irq_mask   (irq_mask),
        .state_err  (state_err)
    );

    pt_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .cmd    (tmr_cmd),
        .expire (expire)
    );

    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (irq_mask && !scan_start && !state_err));
endmodule

// File: tb/sim_pen_trigger_ctrl.sv
`timescale 1ns/1ps
module sim_pen_trigger_ctrl;
    localparam int INTV  = 40;
    localparam int PMIN  = 3;
    localparam int PMAX  = 6;
    localparam int M_OFF = 0, M_IDLE = 1, M_POLL = 2, M_PUN = 3, M_ARM = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic pen_irq_raw = 1'b0;
    logic scan_done = 1'b0;
    logic scan_start, irq_mask, state_err;

    always #2 clk = ~clk;

    pen_trigger_ctrl #(.INTERVAL_CYC(INTV), .POLL_MIN(PMIN), .POLL_MAX(PMAX),
                       .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .enable(enable), .pen_irq_raw(pen_irq_raw),
        .scan_done(scan_done), .scan_start(scan_start), .irq_mask(irq_mask),
        .state_err(state_err)
    );

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    bit    auto_done = 0;
    bit    rand_k = 0;
    int    pend = 0;
    int    starts = 0;

    // reference model state
    bit    m_s1, m_s2, m_mask, m_start, m_err, m_run;
    int    m_state, m_pc, m_cnt, m_dur;
    string m_tag = "R1";

    always @(posedge clk) begin
        automatic bit    pe, ex, cancel, ld_full, ld_scan, nstart, nerr, nmask;
        automatic int    nst, npc;
        automatic string tag;
        if (rst) begin
            m_s1 <= 0; m_s2 <= 0; m_state <= M_OFF; m_pc <= 0; m_mask <= 1;
            m_start <= 0; m_err <= 0; m_run <= 0; m_cnt <= 0; m_dur <= INTV;
            m_tag <= "R1";
        end else begin
            nst = m_state; npc = m_pc; nmask = m_mask; nstart = 0; nerr = 0;
            cancel = 0; ld_full = 0; ld_scan = 0; tag = m_tag;
            pe = enable && m_state != M_OFF && m_s2 && !m_mask;
            ex = m_run && m_cnt == 0;
            if (!enable) begin
                nst = M_OFF; nmask = 1; cancel = 1; tag = "R3";
            end else if (m_state == M_OFF) begin
                nst = M_IDLE; nmask = 0; tag = "R2";
            end else if (pe) begin
                nst = M_ARM; npc = 0; nmask = 1; nstart = 1; cancel = 1;
                tag = ex ? "R12" : (m_state == M_PUN ? "R10" : "R4");
            end else if (ex) begin
                case (m_state)
                    M_ARM: if (m_pc < PMAX) begin
                        npc = m_pc + 1; ld_full = 1; tag = "R7";
                        if (npc >= PMIN) begin nst = M_PUN; nmask = 0; end
                        else nst = M_POLL;
                    end else begin
                        nst = M_IDLE; nmask = 0; tag = "R8";
                    end
                    M_PUN:  begin nmask = 1; nst = M_ARM; nstart = 1; tag = "R9"; end
                    M_POLL: begin nst = M_ARM; nstart = 1; tag = "R9"; end
                    M_IDLE: begin nerr = 1; tag = "R11"; end
                    default: ;
                endcase
            end else if (scan_done) begin
                ld_scan = 1; tag = (m_dur == INTV) ? "R13" : "R6";
            end
            m_s1 <= pen_irq_raw; m_s2 <= m_s1;
            m_dur <= nstart ? 0 : ((m_dur == INTV) ? m_dur : m_dur + 1);
            if (cancel) m_run <= 0;
            else if (ld_full) begin m_cnt <= INTV; m_run <= 1; end
            else if (ld_scan) begin m_cnt <= INTV - m_dur; m_run <= 1; end
            else if (m_run) begin
                if (m_cnt == 0) m_run <= 0; else m_cnt <= m_cnt - 1;
            end
            m_state <= nst; m_pc <= npc; m_mask <= nmask;
            m_start <= nstart; m_err <= nerr; m_tag <= tag;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    function automatic int pick_k();
        if (!rand_k) return 5;
        if ($urandom_range(7) == 0) return INTV + int'($urandom_range(10));
        return 1 + int'($urandom_range(INTV - 2));
    endfunction

    // one clock: compare with the model, then run the scan responder
    task automatic tick();
        @(negedge clk);
        if (!rst)
            chk({scan_start, irq_mask, state_err} === {m_start, m_mask, m_err},
                m_tag, int'({scan_start, irq_mask, state_err}),
                int'({m_start, m_mask, m_err}));
        if (scan_start) starts++;
        scan_done = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) scan_done = 1'b1;
        end
        if (scan_start && auto_done) pend = pick_k();
    endtask

    initial begin
        int c;
        void'($urandom(32'd20240611));
        repeat (3) tick();
        chk(irq_mask === 1'b1 && scan_start === 1'b0 && state_err === 1'b0, "R1",
            int'({scan_start, irq_mask, state_err}), 3'b010);
        rst = 1'b0;

        // R5: pen high while off and masked
        pen_irq_raw = 1'b1;
        c = 0;
        repeat (6) begin tick(); c += int'(scan_start); end
        chk(c == 0 && irq_mask === 1'b1, "R5", c, 0);
        pen_irq_raw = 1'b0;
        repeat (4) tick();

        // R2: enable from off
        enable = 1'b1;
        tick();
        chk(irq_mask === 1'b0, "R2", int'(irq_mask), 0);

        // R4: latency of a one-cycle pen pulse
        auto_done = 1'b1;
        pen_irq_raw = 1'b1;
        tick();
        pen_irq_raw = 1'b0;
        chk(scan_start === 1'b0, "R4", int'(scan_start), 0);
        tick();
        chk(scan_start === 1'b0, "R4", int'(scan_start), 0);
        starts = 0;
        tick();
        chk(scan_start === 1'b1 && irq_mask === 1'b1, "R4",
            int'({scan_start, irq_mask}), 3);

        // R8: full sequence after lift gives 1+POLL_MAX starts, then idle
        repeat (1200) tick();
        chk(starts == 1 + PMAX, "R8", starts, 1 + PMAX);
        chk(irq_mask === 1'b0, "R8", int'(irq_mask), 0);

        // R11 and R13: stray scan_done in idle, saturated duration reloads zero
        scan_done = 1'b1;
        pend = 0;
        tick();
        chk(state_err === 1'b0, "R11", int'(state_err), 0);
        tick();
        chk(state_err === 1'b1, "R11 R13", int'(state_err), 1);
        tick();
        chk(state_err === 1'b0, "R11", int'(state_err), 0);

        // R10: pen held down keeps restarting
        pen_irq_raw = 1'b1;
        starts = 0;
        repeat (2000) tick();
        chk(starts >= 10, "R10", starts, 10);
        pen_irq_raw = 1'b0;
        repeat (1500) tick();
        chk(irq_mask === 1'b0, "R8", int'(irq_mask), 0);

        // R3: disable while polling
        pen_irq_raw = 1'b1;
        tick();
        pen_irq_raw = 1'b0;
        repeat (60) tick();
        enable = 1'b0;
        tick();
        chk(irq_mask === 1'b1, "R3", int'(irq_mask), 1);
        starts = 0;
        c = 0;
        repeat (300) begin tick(); c += int'(state_err); end
        chk(starts == 0 && c == 0, "R3", starts + c, 0);
        enable = 1'b1;
        repeat (3) tick();

        // random phase, compared cycle by cycle against the model (R6, R7, R9, R12)
        rand_k = 1'b1;
        for (int i = 0; i < 80000; i++) begin
            if (!pen_irq_raw && $urandom_range(399) == 0) pen_irq_raw = 1'b1;
            else if (pen_irq_raw && $urandom_range(9) == 0) pen_irq_raw = 1'b0;
            if (enable && $urandom_range(4999) == 0) enable = 1'b0;
            else if (!enable && $urandom_range(19) == 0) enable = 1'b1;
            tick();
            if (pend == 0 && $urandom_range(2999) == 0) scan_done = 1'b1;
        end
        finish_up();
    end

    initial begin
        int wd = 0;
        while (wd < 195000) begin
            @(posedge clk);
            wd++;
        end
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
        finish_up();
    end
endmodule